// File: doc/BRIEF.md
# Paged MDIO 32-bit Register Accessor

This block gives a host single-request access to 32-bit registers inside a switch that is reachable only over a Clause 22 MDIO management bus. The host presents an 18-bit byte address, an operation code, a write value and a mask. The block drives MDC and MDIO itself and runs the complete transaction sequence. When it has finished, it pulses `done` and presents the 32-bit result.

Every operation starts by selecting a page. The upper address bits are written to a fixed page-select register, and the block then waits a settling interval. After that it moves the register as two 16-bit halves to a PHY address and register number that are cut from the lower address bits. A read-modify-write reads both halves, merges the new value under the mask, and writes both halves back. It selects the page and waits only once for the whole sequence.

Top module: `mdio_reg32_access`

## Requirements
- R1: After reset, `busy`, `done`, `mdc` and `mdioOe` are all low.
- R2: Every operation begins with one write frame to PHY address 0x18, register 0, carrying address bits [17:9] as data. Data frames use PHY address 0x10 OR address bits [8:6]. The low half uses register index {addr[5:2],0} and the high half uses that index plus one.
- R3: The first data frame's first MDC rising edge comes at least `SETTLE_CYCLES` clocks (5 µs at `CLK_HZ`) after the page frame's last MDC rising edge. Each operation contains exactly one page frame.
- R4: Operation code 2'b00 reads the low half and then the high half. At `done`, `rdData` is {high, low}. Code 2'b11 behaves the same as 2'b00.
- R5: Operation code 2'b01 writes `reqWdata[15:0]` to the even index and then `reqWdata[31:16]` to the odd index, in that order.
- R6: Operation code 2'b10 reads low then high, then writes low then high. The value written and returned is (old & ~`reqMask`) | `reqWdata`.
- R7: Each frame has 32 ones, start 01, opcode 01 for a write or 10 for a read, 5-bit PHY address, 5-bit register, turnaround 10 on writes, and 16 data bits, with every field sent MSB first. The driven MDIO value changes only on MDC falling edges, so it is stable at every rising edge.
- R8: During a read frame, `mdioOe` is low from the turnaround (bit 46) to the end of the frame. Read data is sampled on MDC rising edges.
- R9: `busy` rises in the cycle after an accepted `reqValid` and stays high until `done`. `done` is a one-cycle pulse. A `reqValid` seen while busy starts nothing and writes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request strobe, taken when idle |
| reqOp | input | 2 | 00 read, 01 write, 10 read-modify-write, 11 read |
| reqAddr | input | 18 | Register byte address |
| reqWdata | input | 32 | Write value, or OR value for read-modify-write |
| reqMask | input | 32 | Bits cleared before the OR in read-modify-write |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| rdData | output | 32 | Read or merged value, valid at done |
| mdc | output | 1 | Management clock |
| mdioOut | output | 1 | MDIO value driven by the block |
| mdioOe | output | 1 | MDIO output enable |
| mdioIn | input | 1 | MDIO value seen at the pin |

## Verification
A wrong address slice or page value sends a frame to the wrong PHY address or register. That shows up in the decoded frame log of the same operation, and as a mismatching readback one operation later. A sequencer that skips or shortens the settling wait shows up as a short gap between the first and second frame. A half-swap or merge error corrupts `rdData` at the very next `done`. A turnaround enable fault shows up at bit 46 of the first read frame.

// File: rtl/mdio_acc_pkg.sv
package mdio_acc_pkg;

  typedef enum logic [1:0] {
    OP_READ  = 2'b00,
    OP_WRITE = 2'b01,
    OP_RMW   = 2'b10,
    OP_RSVD  = 2'b11
  } accOp_t;

  typedef enum logic [1:0] {
    KIND_PAGE = 2'b00,
    KIND_LO   = 2'b01,
    KIND_HI   = 2'b10
  } frameKind_t;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic       accept;
    logic       start;
    frameKind_t kind;
    logic       isRead;
    logic       capLo;
    logic       capHi;
    logic       merge;
  } dpStrobe_t;

  localparam logic [4:0] PAGE_PHY      = 5'h18;
  localparam logic [4:0] DATA_PHY_BASE = 5'h10;
  localparam int         FRAME_BITS    = 64;
  localparam int         TA_BIT        = 46;
  localparam int         DATA_BIT      = 48;

endpackage

// File: rtl/mdio_acc_dp.sv
module mdio_acc_dp
  import mdio_acc_pkg::*;
#(
  parameter int ADDR_W   = 18,
  parameter int DATA_W   = 32,
  parameter int MDC_HALF = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [DATA_W-1:0] reqMask,
  output logic              frameDone,
  output logic [DATA_W-1:0] rdData,
  output logic              mdc,
  output logic              mdioOut,
  output logic              mdioOe,
  input  logic              mdioIn
);

  localparam int HALF_W = DATA_W / 2;
  localparam int PAGE_W = ADDR_W - 9;
  localparam int DIV_W  = $clog2(MDC_HALF) + 1;
  localparam int CNT_W  = $clog2(FRAME_BITS);

  logic [ADDR_W-1:2] addrQ;
  logic [DATA_W-1:0] wdataQ, maskQ, dataQ;

  logic                  active, isReadQ, mdcQ, frameDoneQ;
  logic [DIV_W-1:0]      divCnt;
  logic [CNT_W-1:0]      bitCnt;
  logic [FRAME_BITS-1:0] shReg;
  logic [HALF_W-1:0]     rxReg;

  // address split
  logic [PAGE_W-1:0] pageVal;
  logic [2:0]        phySel;
  logic [4:0]        regIdx;
  assign pageVal = addrQ[ADDR_W-1:9];
  assign phySel  = addrQ[8:6];
  assign regIdx  = {addrQ[5:2], 1'b0};

  logic [4:0]            framePhy, frameReg;
  logic [HALF_W-1:0]     payload;
  logic [FRAME_BITS-1:0] frameWord;

  always_comb begin
    framePhy = PAGE_PHY;
    frameReg = 5'd0;
    payload  = HALF_W'(pageVal);
    case (strobe.kind)
      KIND_LO: begin
        framePhy = DATA_PHY_BASE | {2'b00, phySel};
        frameReg = regIdx;
        payload  = dataQ[HALF_W-1:0];
      end
      KIND_HI: begin
        framePhy = DATA_PHY_BASE | {2'b00, phySel};
        frameReg = regIdx | 5'd1;
        payload  = dataQ[DATA_W-1:HALF_W];
      end
      default: ;
    endcase
    frameWord = {32'hFFFF_FFFF, 2'b01,
                 strobe.isRead ? 2'b10 : 2'b01,
                 framePhy, frameReg,
                 strobe.isRead ? 2'b11 : 2'b10,
                 strobe.isRead ? {HALF_W{1'b1}} : payload};
  end

  logic halfTick;
  assign halfTick = active && (divCnt == DIV_W'(MDC_HALF - 1));

  // frame engine: bits change on MDC fall, input sampled on MDC rise
  always_ff @(posedge clk) begin
    if (!rstN) begin
      active     <= 1'b0;
      isReadQ    <= 1'b0;
      mdcQ       <= 1'b0;
      divCnt     <= '0;
      bitCnt     <= '0;
      shReg      <= '0;
      rxReg      <= '0;
      frameDoneQ <= 1'b0;
    end else begin
      frameDoneQ <= 1'b0;
      if (strobe.start) begin
        active  <= 1'b1;
        isReadQ <= strobe.isRead;
        shReg   <= frameWord;
        bitCnt  <= '0;
        mdcQ    <= 1'b0;
        divCnt  <= '0;
      end else if (active) begin
        if (halfTick) begin
          divCnt <= '0;
          if (!mdcQ) begin
            mdcQ <= 1'b1;
            if (isReadQ && bitCnt >= CNT_W'(DATA_BIT))
              rxReg <= {rxReg[HALF_W-2:0], mdioIn};
          end else begin
            mdcQ   <= 1'b0;
            shReg  <= shReg << 1;
            bitCnt <= bitCnt + 1'b1;
            if (bitCnt == CNT_W'(FRAME_BITS - 1)) begin
              active     <= 1'b0;
              frameDoneQ <= 1'b1;
            end
          end
        end else begin
          divCnt <= divCnt + 1'b1;
        end
      end
    end
  end

  // request capture and data register
  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ  <= '0;
      wdataQ <= '0;
      maskQ  <= '0;
      dataQ  <= '0;
    end else begin
      if (strobe.accept) begin
        addrQ  <= reqAddr[ADDR_W-1:2];
        wdataQ <= reqWdata;
        maskQ  <= reqMask;
        dataQ  <= reqWdata;
      end
      if (strobe.capLo) dataQ[HALF_W-1:0]      <= rxReg;
      if (strobe.capHi) dataQ[DATA_W-1:HALF_W] <= rxReg;
      if (strobe.merge) dataQ <= (dataQ & ~maskQ) | wdataQ;
    end
  end

  assign frameDone = frameDoneQ;
  assign rdData    = dataQ;
  assign mdc       = mdcQ;
  assign mdioOut   = active & shReg[FRAME_BITS-1];
  assign mdioOe    = active && !(isReadQ && bitCnt >= CNT_W'(TA_BIT));

  // R7
  mdc_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !active |=> $stable(mdcQ));

  // R7
  mdio_edge_chk: assert property (@(posedge clk) disable iff (!rstN)
    (active && $past(active) && !$fell(mdcQ)) |-> $stable(mdioOut));

  // R8
  ta_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(mdioOe) && active) |-> (isReadQ && bitCnt == CNT_W'(TA_BIT)));

endmodule

// File: rtl/mdio_acc_ctrl.sv
module mdio_acc_ctrl
  import mdio_acc_pkg::*;
#(
  parameter int SETTLE_CYCLES = 250
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic [1:0] reqOp,
  input  logic       frameDone,
  output dpStrobe_t  strobe,
  output logic       busy,
  output logic       done
);

  localparam int SW = $clog2(SETTLE_CYCLES + 1);

  typedef enum logic [3:0] {
    ST_IDLE, ST_PG, ST_PGW, ST_SETTLE,
    ST_RLO, ST_RLOW, ST_RHI, ST_RHIW, ST_MRG,
    ST_WLO, ST_WLOW, ST_WHI, ST_WHIW, ST_FIN
  } state_t;

  state_t  state, nextState;
  accOp_t  opQ;
  logic [SW-1:0] settleCnt;

  always_comb begin
    nextState = state;
    strobe    = '0;
    case (state)
      ST_IDLE: if (reqValid) begin
        strobe.accept = 1'b1;
        nextState     = ST_PG;
      end
      ST_PG: begin
        strobe.start = 1'b1;
        strobe.kind  = KIND_PAGE;
        nextState    = ST_PGW;
      end
      ST_PGW: if (frameDone) nextState = ST_SETTLE;
      ST_SETTLE: if (settleCnt == SW'(SETTLE_CYCLES - 1))
        nextState = (opQ == OP_WRITE) ? ST_WLO : ST_RLO;
      ST_RLO: begin
        strobe.start  = 1'b1;
        strobe.kind   = KIND_LO;
        strobe.isRead = 1'b1;
        nextState     = ST_RLOW;
      end
      ST_RLOW: if (frameDone) begin
        strobe.capLo = 1'b1;
        nextState    = ST_RHI;
      end
      ST_RHI: begin
        strobe.start  = 1'b1;
        strobe.kind   = KIND_HI;
        strobe.isRead = 1'b1;
        nextState     = ST_RHIW;
      end
      ST_RHIW: if (frameDone) begin
        strobe.capHi = 1'b1;
        nextState    = (opQ == OP_RMW) ? ST_MRG : ST_FIN;
      end
      ST_MRG: begin
        strobe.merge = 1'b1;
        nextState    = ST_WLO;
      end
      ST_WLO: begin
        strobe.start = 1'b1;
        strobe.kind  = KIND_LO;
        nextState    = ST_WLOW;
      end
      ST_WLOW: if (frameDone) nextState = ST_WHI;
      ST_WHI: begin
        strobe.start = 1'b1;
        strobe.kind  = KIND_HI;
        nextState    = ST_WHIW;
      end
      ST_WHIW: if (frameDone) nextState = ST_FIN;
      ST_FIN:  nextState = ST_IDLE;
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      opQ       <= OP_READ;
      settleCnt <= '0;
    end else begin
      state <= nextState;
      if (strobe.accept) opQ <= accOp_t'(reqOp);
      if (state == ST_SETTLE) settleCnt <= settleCnt + 1'b1;
      else                    settleCnt <= '0;
    end
  end

  assign busy = (state != ST_IDLE);
  assign done = (state == ST_FIN);

  // cycles since the page frame finished, saturating
  logic [SW-1:0] gapCnt;
  always_ff @(posedge clk) begin
    if (!rstN) gapCnt <= '0;
    else if (state == ST_PGW && frameDone) gapCnt <= '0;
    else if (gapCnt < SW'(SETTLE_CYCLES)) gapCnt <= gapCnt + 1'b1;
  end

  // R3
  settle_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.start && strobe.kind == KIND_LO) |-> gapCnt >= SW'(SETTLE_CYCLES));

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R9
  busy_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(reqValid));

endmodule

// File: rtl/mdio_reg32_access.sv
module mdio_reg32_access
  import mdio_acc_pkg::*;
#(
  parameter int CLK_HZ    = 50_000_000,
  parameter int SETTLE_US = 5,
  parameter int MDC_HALF  = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic [1:0]  reqOp,
  input  logic [17:0] reqAddr,
  input  logic [31:0] reqWdata,
  input  logic [31:0] reqMask,
  output logic        busy,
  output logic        done,
  output logic [31:0] rdData,
  output logic        mdc,
  output logic        mdioOut,
  output logic        mdioOe,
  input  logic        mdioIn
);

  localparam int SETTLE_RAW    = (CLK_HZ / 1_000_000) * SETTLE_US;
  localparam int SETTLE_CYCLES = (SETTLE_RAW < 1) ? 1 : SETTLE_RAW;

  dpStrobe_t strobe;
  logic      frameDone;

  mdio_acc_ctrl #(.SETTLE_CYCLES(SETTLE_CYCLES)) ctrlInst (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOp(reqOp),
    .frameDone(frameDone), .strobe(strobe), .busy(busy), .done(done)
  );

  mdio_acc_dp #(.ADDR_W(18), .DATA_W(32), .MDC_HALF(MDC_HALF)) dpInst (
    .clk(clk), .rstN(rstN), .strobe(strobe), .reqAddr(reqAddr),
    .reqWdata(reqWdata), .reqMask(reqMask), .frameDone(frameDone),
    .rdData(rdData), .mdc(mdc), .mdioOut(mdioOut), .mdioOe(mdioOe),
    .mdioIn(mdioIn)
  );

endmodule

// File: tb/mdio_reg32_access_test.sv
`timescale 1ns/1ps
module mdio_reg32_access_test;

  localparam int CLK_PERIOD = 20;
  localparam int SETTLE     = 250;   // 5 us at 50 MHz
  localparam int MDC_HALF   = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic [1:0] reqOp = 2'b00;
  logic [17:0] reqAddr = '0;
  logic [31:0] reqWdata = '0, reqMask = '0;
  logic busy, done, mdc, mdioOut, mdioOe;
  logic [31:0] rdData;
  logic mdioIn = 1'b1;

  always #(CLK_PERIOD/2) clk = ~clk;

  mdio_reg32_access uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOp(reqOp),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .reqMask(reqMask),
    .busy(busy), .done(done), .rdData(rdData), .mdc(mdc),
    .mdioOut(mdioOut), .mdioOe(mdioOe), .mdioIn(mdioIn)
  );

  int checks = 0, failures = 0, cyc = 0;
  bit finished = 0;
  always @(posedge clk) cyc++;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // ---------------- PHY / switch model ----------------
  function automatic logic [15:0] defVal(input int key);
    return 16'((key * 40503) ^ 23130);
  endfunction

  logic [15:0] mem [int];
  logic [8:0]  pageReg = '0;
  logic        bits [0:63];
  int          bitPos = 0;
  bit          curRead = 0;
  logic [4:0]  curPhy, curReg;
  logic [15:0] rdWord = '0;
  bit          curFmt = 1;
  int          startCyc = 0, oeBad = 0, badPhy = 0;

  int          logCnt = 0;
  bit          logRd  [8];
  logic [4:0]  logPhy [8];
  logic [4:0]  logReg [8];
  logic [15:0] logData[8];
  bit          logFmt [8];
  int          logStart[8];
  int          logEnd [8];

  always @(posedge mdc) begin
    bits[bitPos] = mdioOut;
    if (bitPos == 0) startCyc = cyc;
    if (bitPos >= 46 && curRead && mdioOe) oeBad++;
    if (bitPos == 45) begin
      curFmt = 1;
      for (int k = 0; k < 32; k++) if (bits[k] !== 1'b1) curFmt = 0;
      if (bits[32] !== 1'b0 || bits[33] !== 1'b1) curFmt = 0;
      if ({bits[34], bits[35]} == 2'b10) curRead = 1;
      else begin
        curRead = 0;
        if ({bits[34], bits[35]} != 2'b01) curFmt = 0;
      end
      for (int k = 0; k < 5; k++) begin
        curPhy[4-k] = bits[36+k];
        curReg[4-k] = bits[41+k];
      end
      if (curRead) begin
        int key;
        key = int'(pageReg) * 1024 + int'(curPhy[2:0]) * 32 + int'(curReg);
        rdWord = mem.exists(key) ? mem[key] : defVal(key);
      end
    end
    if (bitPos == 63) begin
      logic [15:0] d;
      for (int k = 0; k < 16; k++) d[15-k] = bits[48+k];
      if (!curRead) begin
        if (bits[46] !== 1'b1 || bits[47] !== 1'b0) curFmt = 0;
        if (curPhy == 5'h18 && curReg == 5'd0) pageReg = d[8:0];
        else if (curPhy[4:3] == 2'b10)
          mem[int'(pageReg) * 1024 + int'(curPhy[2:0]) * 32 + int'(curReg)] = d;
        else badPhy++;
      end else d = rdWord;
      if (logCnt < 8) begin
        logRd[logCnt] = curRead; logPhy[logCnt] = curPhy; logReg[logCnt] = curReg;
        logData[logCnt] = d; logFmt[logCnt] = curFmt;
        logStart[logCnt] = startCyc; logEnd[logCnt] = cyc;
      end
      logCnt++;
      bitPos = 0;
      curRead = 0;
    end else bitPos++;
  end

  always @(negedge mdc)
    mdioIn = (curRead && bitPos >= 48) ? rdWord[63-bitPos] : 1'b1;

  // ---------------- expectations ----------------
  logic [31:0] shadow [int];

  function automatic int loKey(input logic [17:0] a);
    return int'(a >> 9) * 1024 + int'((a >> 6) & 7) * 32 + int'((a >> 2) & 15) * 2;
  endfunction

  function automatic logic [31:0] expVal(input logic [17:0] a);
    if (shadow.exists(int'(a))) return shadow[int'(a)];
    return {defVal(loKey(a) + 1), defVal(loKey(a))};
  endfunction

  task automatic runOp(input logic [1:0] op, input logic [17:0] a,
                       input logic [31:0] wd, input logic [31:0] mk,
                       output logic [31:0] rd);
    logCnt = 0;
    @(negedge clk);
    reqOp = op; reqAddr = a; reqWdata = wd; reqMask = mk; reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    chk(busy === 1'b1, "R9 busy after accept", {31'd0, busy}, 32'd1);
    while (done !== 1'b1) @(negedge clk);
    rd = rdData;
    @(negedge clk);
    chk(done === 1'b0 && busy === 1'b0, "R9 done one cycle", {30'd0, done, busy}, 32'd0);
  endtask

  // page frame, settle and data frame addressing shared by all ops
  task automatic chkCommon(input logic [17:0] a, input int nFrames);
    logic [4:0] ePhy, eReg;
    int gap;
    ePhy = 5'h10 | 5'((a >> 6) & 7);
    eReg = 5'(((a >> 2) & 15) * 2);
    chk(logCnt == nFrames, "R3 frame count", logCnt, nFrames);
    chk(!logRd[0] && logPhy[0] == 5'h18 && logReg[0] == 5'd0,
        "R2 page frame target", {logRd[0], logPhy[0], logReg[0]}, {1'b0, 5'h18, 5'd0});
    chk(logData[0] == 16'(a >> 9), "R2 page value", logData[0], 16'(a >> 9));
    chk(logPhy[1] == ePhy && logReg[1] == eReg && logPhy[2] == ePhy && logReg[2] == eReg + 5'd1,
        "R2 data frame addresses", {logPhy[1], logReg[1], logPhy[2], logReg[2]},
        {ePhy, eReg, ePhy, eReg + 5'd1});
    gap = logStart[1] - logEnd[0];
    chk(gap >= SETTLE && gap <= SETTLE + 4 * MDC_HALF + 8, "R3 settle gap", gap, SETTLE);
    for (int f = 0; f < nFrames; f++)
      chk(logFmt[f], "R7 frame format", f, 32'd1);
  endtask

  logic [31:0] rd, ev, merged;

  initial begin
    repeat (5) @(negedge clk);
    // R1
    chk(busy === 0 && done === 0 && mdc === 0 && mdioOe === 0, "R1 reset outputs",
        {28'd0, busy, done, mdc, mdioOe}, 32'd0);
    rstN = 1'b1;
    @(negedge clk);

    // sweep: write then read back over many address slices
    for (int i = 0; i < 12; i++) begin
      logic [17:0] a;
      logic [31:0] wd;
      a  = 18'((((i * 97) % 512) << 9) | ((i % 8) << 6) | (((i * 7) % 16) << 2));
      if (i == 11) a = 18'h3FFFC;
      wd = 32'h1234_5678 ^ (32'(i) * 32'h0101_1F3B);
      runOp(2'b01, a, wd, 32'h0, rd);
      chkCommon(a, 3);
      chk(!logRd[1] && !logRd[2] && logData[1] == wd[15:0] && logData[2] == wd[31:16],
          "R5 write halves order", {logData[2], logData[1]}, wd);
      shadow[int'(a)] = wd;
      runOp((i == 5) ? 2'b11 : 2'b00, a, 32'h0, 32'h0, rd);
      chkCommon(a, 3);
      chk(logRd[1] && logRd[2], "R4 read frames", {logRd[1], logRd[2]}, 2'b11);
      chk(rd == wd, "R4 read back", rd, wd);
      chk(oeBad == 0, "R8 released during read", oeBad, 0);
    end

    // reads of never-written registers
    for (int i = 0; i < 3; i++) begin
      logic [17:0] a;
      a = 18'(18'h2A5C0 + i * 18'h244);
      runOp(2'b00, a, 32'h0, 32'h0, rd);
      ev = expVal(a);
      chk(rd == ev, "R4 read assembly high:low", rd, ev);
    end

    // read-modify-write
    for (int i = 0; i < 3; i++) begin
      logic [17:0] a;
      logic [31:0] mk, wd;
      a  = (i == 0) ? 18'h00040 : 18'(18'h15A4C + i * 18'h608);
      mk = 32'hFF00_F0F0 >> i;
      wd = 32'h0A0B_0C0D << i;
      ev = expVal(a);
      merged = (ev & ~mk) | wd;
      runOp(2'b10, a, wd, mk, rd);
      chkCommon(a, 5);
      chk(logRd[1] && logRd[2] && !logRd[3] && !logRd[4], "R6 op order",
          {logRd[1], logRd[2], logRd[3], logRd[4]}, 4'b1100);
      chk(logData[3] == merged[15:0] && logData[4] == merged[31:16] &&
          logReg[3] == logReg[1] && logReg[4] == logReg[2],
          "R6 written merge", {logData[4], logData[3]}, merged);
      chk(rd == merged, "R6 returned merge", rd, merged);
      shadow[int'(a)] = merged;
      runOp(2'b00, a, 32'h0, 32'h0, rd);
      chk(rd == merged, "R6 merge stored", rd, merged);
    end

    // request while busy is ignored
    begin
      logic [17:0] aA, aB;
      aA = 18'h0F0F0; aB = 18'h31234;
      fork
        runOp(2'b01, aA, 32'hCAFE_F00D, 32'h0, rd);
        begin
          repeat (60) @(negedge clk);
          reqOp = 2'b01; reqAddr = aB; reqWdata = 32'hDEAD_BEEF; reqValid = 1'b1;
          @(negedge clk);
          reqValid = 1'b0;
        end
      join
      shadow[int'(aA)] = 32'hCAFE_F00D;
      chk(logCnt == 3, "R9 no extra frames", logCnt, 3);
      repeat (20) @(negedge clk);
      chk(busy === 1'b0, "R9 stays idle", {31'd0, busy}, 32'd0);
      runOp(2'b00, aB, 32'h0, 32'h0, rd);
      ev = expVal(aB);
      chk(rd == ev, "R9 ignored write had no effect", rd, ev);
      runOp(2'b00, aA, 32'h0, 32'h0, rd);
      chk(rd == 32'hCAFE_F00D, "R9 accepted write kept", rd, 32'hCAFE_F00D);
    end

    chk(badPhy == 0, "R2 no stray PHY address", badPhy, 0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule